// File: doc/BRIEF.md
# Indirect Control Register File for a Network Controller

This block is the register face of a network controller as a host sees it. It has a single 16-bit host port with a select line: a write with the select high loads a register pointer, and the following data-port accesses reach whichever of the four registers that pointer names. The pointer stays put until it is written again. Reads are combinational: `host_rdata` always shows the register the pointer selects.

Register 0 is the command and status word. It mixes three kinds of bit. Some are self-acting commands: stop, initialise, start and transmit demand. Some are sticky status bits that the host clears by writing ones. Two are summaries derived from the others: an error summary and an interrupt flag. Registers 1 and 2 hold the initialisation block address, and register 3 holds bus control bits. Those three can only be changed while the controller is stopped. An initialise command completes after a fixed, parameterised latency; the memory fetch that the latency stands for is not modelled. Six event inputs set the matching status bits, and the interrupt output is the interrupt flag gated by an enable bit.

Top module: `lnc_csr_file`

## Requirements
- R1: A write with `host_ptr_sel`=1 loads the pointer from `host_wdata[1:0]` and ignores the upper bits. Data-port writes (`host_ptr_sel`=0) and `host_rdata` then act on register 0, 1, 2 or 3 as selected, until the pointer is written again.
- R2: After reset, register 0 reads 0x0004, registers 1 to 3 read 0, the pointer selects register 0 and `irq_o` is low.
- R3: Register 0 bit layout: 0 INIT, 1 STRT, 2 STOP, 3 TDMD, 4 TXON, 5 RXON, 6 INEA, 7 INTR, 8 IDON, 9 TINT, 10 RINT, 11 MERR, 12 MISS, 13 CERR, 14 BABL, 15 ERR. Any register 0 write with bit 2 set makes register 0 read exactly 0x0004 on the next cycle, whatever else the write carries.
- R4: A register 0 write with INIT=1 (and STOP=0) sets INIT and clears STOP. IDON becomes 1, and INIT returns to 0, exactly INIT_LATENCY clock edges after the edge that took the write. A STOP write during that wait cancels it.
- R5: IDON, TINT, RINT, MERR, MISS, CERR and BABL are sticky. Writing 1 to one of these bits clears it, and writing 0 leaves it as it is. A single write of IDON|STRT clears IDON and starts the controller.
- R6: A register 0 write with STRT=1 sets STRT, TXON and RXON and clears STOP. Writing 0 to INIT or STRT has no effect.
- R7: A register 0 write with TDMD=1 makes TDMD read 1 for one cycle; it then reads 0 unless it is written again.
- R8: While STOP reads 1, the event inputs are ignored. Otherwise tx done sets TINT, rx done sets RINT, babble sets BABL, collision sets CERR, miss sets MISS and memory error sets MERR. An event wins over a write-one-to-clear of the same bit in the same cycle.
- R9: ERR reads as BABL|CERR|MISS|MERR. INTR reads as ERR|RINT|TINT|IDON.
- R10: Every register 0 write without STOP loads INEA from bit 6. `irq_o` equals INTR AND INEA.
- R11: Register 1 holds init address bits 15:0. Register 2 holds bits INIT_ADDR_W-1:16 in its low bits and reads 0 above them. Register 3 holds BSWP at bit 2, ACON at bit 1 and BCON at bit 0, and reads 0 above them. Writes to registers 1 to 3 take effect only while STOP is 1 and are ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_ptr_sel | input | 1 | 1: write goes to the pointer; 0: write goes to the selected register |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Contents of the selected register |
| ev_tx_done | input | 1 | Transmit completion event |
| ev_rx_done | input | 1 | Receive completion event |
| ev_babble | input | 1 | Transmitter babble event |
| ev_collision | input | 1 | Collision error event |
| ev_miss | input | 1 | Missed frame event |
| ev_mem_err | input | 1 | Memory error event |
| irq_o | output | 1 | Interrupt request |

## Verification
Register 0 is driven with command words that combine several bit kinds in one write. STOP together with every other bit shows that STOP takes priority. IDON|STRT shows that a clear and a start can share one write. Writes with a status bit at 0 and then at 1 show the difference between leaving a sticky bit alone and clearing it. Each error event is raised on its own, which shows that each one reaches the error summary by itself. An event arriving in the same cycle as a clear of the same bit shows which of the two has priority. The IDON flag is sampled one cycle before and on the exact latency edge, and a STOP issued mid-wait shows that the pending completion is dropped. The address and control registers are written once while stopped and once while running, which separates an accepted write from an ignored one.

// File: rtl/lnc_csr_pkg.sv
// Package: shared register 0 bit positions, masks and the register word type.
// Assumes a 16-bit host data path.
package lnc_csr_pkg;
    localparam int WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;

    localparam int B_INIT = 0;
    localparam int B_STRT = 1;
    localparam int B_STOP = 2;
    localparam int B_TDMD = 3;
    localparam int B_TXON = 4;
    localparam int B_RXON = 5;
    localparam int B_INEA = 6;
    localparam int B_INTR = 7;
    localparam int B_IDON = 8;
    localparam int B_TINT = 9;
    localparam int B_RINT = 10;
    localparam int B_MERR = 11;
    localparam int B_MISS = 12;
    localparam int B_CERR = 13;
    localparam int B_BABL = 14;
    localparam int B_ERR  = 15;

    localparam word_t STOP_ONLY = word_t'(1) << B_STOP;
    localparam word_t W1C_MASK  = (word_t'(1) << B_IDON) | (word_t'(1) << B_TINT)
                                | (word_t'(1) << B_RINT) | (word_t'(1) << B_MERR)
                                | (word_t'(1) << B_MISS) | (word_t'(1) << B_CERR)
                                | (word_t'(1) << B_BABL);

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_ADLO = 2'd1,
        SEL_ADHI = 2'd2,
        SEL_BUS  = 2'd3
    } reg_sel_t;
endpackage

// File: rtl/lnc_init_timer.sv
// Module: counts the initialisation latency and pulses done on its last edge.
// Assumes LATENCY >= 1. A new start restarts the count; abort cancels it.
module lnc_init_timer #(
    parameter int LATENCY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    output logic done_o
);
    localparam int CW = $clog2(LATENCY + 1);

    logic [CW-1:0] cnt_q;

    // Done is raised on the edge where the count runs out.
    assign done_o = (cnt_q == CW'(1));

    // Load, count down or cancel the pending initialisation.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= CW'(LATENCY);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    AST_DONE_ENDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o) else $error("done held"); // R4
endmodule

// File: rtl/lnc_cmd_status.sv
// Module: register 0, with its commands, sticky status, summaries and event capture.
// Assumes wr_i is a data-port write while register 0 is selected.
module lnc_cmd_status
    import lnc_csr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_i,
    input  word_t wdata_i,
    input  logic  init_done_i,
    input  logic  ev_tx_i,
    input  logic  ev_rx_i,
    input  logic  ev_babl_i,
    input  logic  ev_cerr_i,
    input  logic  ev_miss_i,
    input  logic  ev_merr_i,
    output word_t rdata_o,
    output logic  stopped_o,
    output logic  init_start_o,
    output logic  stop_cmd_o
);
    word_t q, nxt;
    logic  err, intr;

    assign stop_cmd_o   = wr_i && wdata_i[B_STOP];
    assign init_start_o = wr_i && wdata_i[B_INIT] && !wdata_i[B_STOP];
    assign stopped_o    = q[B_STOP];

    // Summary bits derived from the stored status.
    assign err  = q[B_BABL] | q[B_CERR] | q[B_MISS] | q[B_MERR];
    assign intr = err | q[B_RINT] | q[B_TINT] | q[B_IDON];

    // Read view: the stored bits with the two summaries filled in.
    always_comb begin
        rdata_o         = q;
        rdata_o[B_ERR]  = err;
        rdata_o[B_INTR] = intr;
    end

    // Next state when no STOP is written: commands, clears, completion, events.
    always_comb begin
        nxt         = q;
        nxt[B_TDMD] = 1'b0;
        if (wr_i) begin
            nxt         = nxt & ~(wdata_i & W1C_MASK);
            nxt[B_INEA] = wdata_i[B_INEA];
            if (wdata_i[B_INIT]) begin
                nxt[B_INIT] = 1'b1;
                nxt[B_STOP] = 1'b0;
            end
            if (wdata_i[B_STRT]) begin
                nxt[B_STRT] = 1'b1;
                nxt[B_TXON] = 1'b1;
                nxt[B_RXON] = 1'b1;
                nxt[B_STOP] = 1'b0;
            end
            if (wdata_i[B_TDMD]) begin
                nxt[B_TDMD] = 1'b1;
            end
        end
        if (init_done_i) begin
            nxt[B_IDON] = 1'b1;
            nxt[B_INIT] = 1'b0;
        end
        if (!q[B_STOP]) begin
            nxt[B_TINT] = nxt[B_TINT] | ev_tx_i;
            nxt[B_RINT] = nxt[B_RINT] | ev_rx_i;
            nxt[B_BABL] = nxt[B_BABL] | ev_babl_i;
            nxt[B_CERR] = nxt[B_CERR] | ev_cerr_i;
            nxt[B_MISS] = nxt[B_MISS] | ev_miss_i;
            nxt[B_MERR] = nxt[B_MERR] | ev_merr_i;
        end
    end

    // Register update; a STOP write forces the stopped state.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_cmd_o) begin
            q <= STOP_ONLY;
        end else begin
            q <= nxt;
        end
    end

    AST_STOP_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd_o |=> (rdata_o == STOP_ONLY)) else $error("stop readback"); // R3
    AST_TDMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q[B_TDMD] && !(wr_i && wdata_i[B_TDMD])) |=> !q[B_TDMD]) else $error("tdmd held"); // R7
    AST_IDON_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done_i && !stop_cmd_o) |=> q[B_IDON]) else $error("idon missing"); // R4
    AST_START_LEAVES_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[B_STRT] && !wdata_i[B_STOP]) |=> (!q[B_STOP] && q[B_TXON] && q[B_RXON])) else $error("start"); // R6
endmodule

// File: rtl/lnc_cfg_regs.sv
// Module: registers 1 to 3 (init block address halves and bus control).
// Assumes 17 <= ADDR_W <= 32; writes are accepted only while stopped.
module lnc_cfg_regs
    import lnc_csr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_i,
    input  reg_sel_t sel_i,
    input  word_t    wdata_i,
    input  logic     stopped_i,
    output word_t    adlo_o,
    output word_t    adhi_o,
    output word_t    bus_o
);
    localparam int HI_W  = ADDR_W - WORD_W;
    localparam int BUS_W = 3;

    logic [HI_W-1:0]  hi_q;
    logic [BUS_W-1:0] bus_q;
    logic             wr_ok;

    assign wr_ok = wr_i && stopped_i;

    // Store the writable fields, locked while the controller runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adlo_o <= '0;
            hi_q   <= '0;
            bus_q  <= '0;
        end else if (wr_ok) begin
            if (sel_i == SEL_ADLO) adlo_o <= wdata_i;
            if (sel_i == SEL_ADHI) hi_q   <= wdata_i[HI_W-1:0];
            if (sel_i == SEL_BUS)  bus_q  <= wdata_i[BUS_W-1:0];
        end
    end

    // Zero-extend the high address part unless it fills the word.
    generate
        if (HI_W == WORD_W) begin : g_hi_full
            assign adhi_o = hi_q;
        end else begin : g_hi_part
            assign adhi_o = {{(WORD_W-HI_W){1'b0}}, hi_q};
        end
    endgenerate

    assign bus_o = {{(WORD_W-BUS_W){1'b0}}, bus_q};

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !stopped_i |=> ($stable(adlo_o) && $stable(hi_q) && $stable(bus_q))) else $error("cfg changed"); // R11
endmodule

// File: rtl/lnc_csr_file.sv
// Module: top; holds the register pointer and routes host accesses and reads.
// Assumes a single host and combinational read of the selected register.
module lnc_csr_file
    import lnc_csr_pkg::*;
#(
    parameter int INIT_LATENCY = 8,
    parameter int INIT_ADDR_W  = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic        host_ptr_sel,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic        ev_tx_done,
    input  logic        ev_rx_done,
    input  logic        ev_babble,
    input  logic        ev_collision,
    input  logic        ev_miss,
    input  logic        ev_mem_err,
    output logic        irq_o
);
    reg_sel_t ptr_q;
    word_t    cmd_rd, adlo, adhi, busc;
    logic     data_wr, cmd_wr, stopped, init_start, stop_cmd, init_done;

    assign data_wr = host_we && !host_ptr_sel;
    assign cmd_wr  = data_wr && (ptr_q == SEL_CMD);

    // Register pointer, loaded from the address port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= SEL_CMD;
        end else if (host_we && host_ptr_sel) begin
            ptr_q <= reg_sel_t'(host_wdata[1:0]);
        end
    end

    lnc_cmd_status u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (cmd_wr),
        .wdata_i      (host_wdata),
        .init_done_i  (init_done),
        .ev_tx_i      (ev_tx_done),
        .ev_rx_i      (ev_rx_done),
        .ev_babl_i    (ev_babble),
        .ev_cerr_i    (ev_collision),
        .ev_miss_i    (ev_miss),
        .ev_merr_i    (ev_mem_err),
        .rdata_o      (cmd_rd),
        .stopped_o    (stopped),
        .init_start_o (init_start),
        .stop_cmd_o   (stop_cmd)
    );

    lnc_init_timer #(.LATENCY(INIT_LATENCY)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (init_start),
        .abort_i (stop_cmd),
        .done_o  (init_done)
    );

    lnc_cfg_regs #(.ADDR_W(INIT_ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (data_wr),
        .sel_i     (ptr_q),
        .wdata_i   (host_wdata),
        .stopped_i (stopped),
        .adlo_o    (adlo),
        .adhi_o    (adhi),
        .bus_o     (busc)
    );

    // Read mux over the four registers.
    always_comb begin
        case (ptr_q)
            SEL_CMD:  host_rdata = cmd_rd;
            SEL_ADLO: host_rdata = adlo;
            SEL_ADHI: host_rdata = adhi;
            default:  host_rdata = busc;
        endcase
    end

    assign irq_o = cmd_rd[B_INTR] & cmd_rd[B_INEA];

    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q == SEL_CMD) |-> (host_rdata[B_ERR] == (|host_rdata[B_BABL:B_MERR]))) else $error("err summary"); // R9
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cmd_rd[B_INEA] && cmd_rd[B_INTR])) else $error("irq gating"); // R10
endmodule

// File: tb/tb_lnc_csr_file.sv
module tb_lnc_csr_file;
    localparam int CLK_P = 10;
    localparam int LAT   = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_ptr_sel = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        ev_tx_done = 1'b0, ev_rx_done = 1'b0, ev_babble = 1'b0;
    logic        ev_collision = 1'b0, ev_miss = 1'b0, ev_mem_err = 1'b0;
    logic        irq_o;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_P/2) clk = ~clk;

    lnc_csr_file #(.INIT_LATENCY(LAT), .INIT_ADDR_W(24)) dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_ptr_sel(host_ptr_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done), .ev_babble(ev_babble),
        .ev_collision(ev_collision), .ev_miss(ev_miss), .ev_mem_err(ev_mem_err),
        .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // One host write; returns at the negedge after the capturing edge.
    task automatic hw(input logic sel, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_ptr_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_ptr_sel = 1'b0; host_wdata = '0;
    endtask

    task automatic t_reset();
        chk("R2 cmd reset", host_rdata, 16'h0004);
        chk("R2 irq reset", {15'd0, irq_o}, 16'h0000);
        hw(1'b1, 16'h0001); chk("R2 adlo reset", host_rdata, 16'h0000);
        hw(1'b1, 16'h0003); chk("R2 bus reset", host_rdata, 16'h0000);
    endtask

    task automatic t_cfg_stopped();
        hw(1'b1, 16'h0001); hw(1'b0, 16'hBEEF);
        chk("R11 adlo write", host_rdata, 16'hBEEF);
        hw(1'b0, 16'h1357);
        chk("R1 pointer persists", host_rdata, 16'h1357);
        hw(1'b0, 16'hBEEF);
        hw(1'b1, 16'h0002); hw(1'b0, 16'hFFFF);
        chk("R11 adhi width", host_rdata, 16'h00FF);
        hw(1'b1, 16'h0003); hw(1'b0, 16'hFFFF);
        chk("R11 bus width", host_rdata, 16'h0007);
        hw(1'b1, 16'hFFFD);
        chk("R1 pointer low bits", host_rdata, 16'hBEEF);
        hw(1'b1, 16'h0000);
    endtask

    task automatic t_events_stopped();
        @(negedge clk);
        {ev_tx_done, ev_rx_done, ev_babble, ev_collision, ev_miss, ev_mem_err} = '1;
        @(negedge clk);
        {ev_tx_done, ev_rx_done, ev_babble, ev_collision, ev_miss, ev_mem_err} = '0;
        chk("R8 events while stopped", host_rdata, 16'h0004);
    endtask

    task automatic t_init();
        hw(1'b0, 16'h0041);
        chk("R4 init issued", host_rdata, 16'h0041);
        repeat (LAT-1) @(negedge clk);
        chk("R4 idon not early", host_rdata, 16'h0041);
        @(negedge clk);
        chk("R4 idon on time", host_rdata, 16'h01C0);
        chk("R10 irq on idon", {15'd0, irq_o}, 16'h0001);
        hw(1'b1, 16'h0001); hw(1'b0, 16'h1234);
        chk("R11 adlo locked", host_rdata, 16'hBEEF);
        hw(1'b1, 16'h0000);
    endtask

    task automatic t_start();
        hw(1'b0, 16'h0142);
        chk("R5 R6 idon clear and start", host_rdata, 16'h0072);
        chk("R10 irq low", {15'd0, irq_o}, 16'h0000);
        hw(1'b0, 16'h0048);
        chk("R7 tdmd set", host_rdata, 16'h007A);
        @(negedge clk);
        chk("R7 tdmd self clear", host_rdata, 16'h0072);
    endtask

    task automatic t_events();
        @(negedge clk); ev_tx_done = 1'b1; @(negedge clk); ev_tx_done = 1'b0;
        chk("R8 tint", host_rdata, 16'h02F2);
        chk("R10 irq tint", {15'd0, irq_o}, 16'h0001);
        hw(1'b0, 16'h0040);
        chk("R5 zero keeps", host_rdata, 16'h02F2);
        hw(1'b0, 16'h0240);
        chk("R5 one clears", host_rdata, 16'h0072);
        @(negedge clk); ev_babble = 1'b1; @(negedge clk); ev_babble = 1'b0;
        chk("R9 babl err", host_rdata, 16'hC0F2);
        hw(1'b0, 16'h4040);
        @(negedge clk); ev_collision = 1'b1; @(negedge clk); ev_collision = 1'b0;
        chk("R9 cerr err", host_rdata, 16'hA0F2);
        hw(1'b0, 16'h2040);
        @(negedge clk); ev_miss = 1'b1; @(negedge clk); ev_miss = 1'b0;
        chk("R9 miss err", host_rdata, 16'h90F2);
        hw(1'b0, 16'h1040);
        @(negedge clk); ev_mem_err = 1'b1; @(negedge clk); ev_mem_err = 1'b0;
        chk("R9 merr err", host_rdata, 16'h88F2);
        hw(1'b0, 16'h0840);
        chk("R9 cleared", host_rdata, 16'h0072);
        @(negedge clk);
        ev_rx_done = 1'b1; host_we = 1'b1; host_wdata = 16'h0440;
        @(negedge clk);
        ev_rx_done = 1'b0; host_we = 1'b0; host_wdata = '0;
        chk("R8 event beats clear", host_rdata, 16'h04F2);
        hw(1'b0, 16'h0000);
        chk("R10 inea off", host_rdata, 16'h04B2);
        chk("R10 irq masked", {15'd0, irq_o}, 16'h0000);
    endtask

    task automatic t_stop();
        hw(1'b0, 16'hFFFF);
        chk("R3 stop overrides", host_rdata, 16'h0004);
        hw(1'b0, 16'h0001);
        chk("R4 init again", host_rdata, 16'h0001);
        hw(1'b0, 16'h0004);
        repeat (LAT+2) @(negedge clk);
        chk("R4 stop cancels init", host_rdata, 16'h0004);
    endtask

    initial begin
        #(CLK_P*20000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_stopped();
        t_events_stopped();
        t_init();
        t_start();
        t_events();
        t_stop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule